// File: doc/BRIEF.md
# Card-Select and Joystick Port Register

This block is the single I/O register that sits at port address 0x1F of an 8-bit processor's I/O space on a storage and serial expansion card. A processor write to the port sets two active-low chip selects for two memory-card slots and a bit that arms an interrupt request on serial receive activity. A processor read of the same port returns the state of a five-line joystick, provided a jumper pulls the joystick-enable pin low.

The block watches the processor's I/O request, read and write strobes and the low address byte. A write is latched only after the strobe has been held for a fixed number of clock edges, which places the capture point in the middle of the bus cycle. A hardware interlock sees to it that a written value never asserts both card selects. The block also drives the data-bus output enable for its own read cycles. A build parameter selects a reduced mode in which this port still accepts writes but never answers reads.

Top module: `cs_joy_port`

## Requirements
- R1: While reset is asserted, both card selects are high (inactive) and the interrupt arm bit is 0.
- R2: A write to address 0x1F, held for LATCH_CYC+1 rising clock edges (default 2), captures data bit 0 into card select 0 and data bit 1 into card select 1. Both selects are active low. The new value is visible after the capturing edge.
- R3: A write whose bits 1:0 are both 0 leaves both card selects high.
- R4: The two card select outputs are never low at the same time.
- R5: Data bit 3 of a write sets the interrupt arm bit. The interrupt request output equals the arm bit ANDed with the serial receive event input.
- R6: In full mode, a read of 0x1F while the enable pin is low raises the output enable. The data bus then carries the joystick lines in bits 4:0 (1 = active) and 0 in bits 7:5.
- R7: While the enable pin is high, a read of 0x1F leaves the output enable low and the data output at 0.
- R8: In reduced mode (FULL_MODE = 0), a read of 0x1F never raises the output enable, but writes still update the card selects.
- R9: Writes to other addresses, and write strobes held for fewer than LATCH_CYC+1 edges, change nothing.
- R10: One write strobe captures at most once. A data change later in the same strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock (the inverted processor clock) |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 8 | Low address byte |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | Data bus from processor |
| joy_in | input | 5 | Joystick lines, 1 = active |
| joy_en_n | input | 1 | Joystick read enable jumper, active low |
| rx_event | input | 1 | Serial receive event |
| card_sel_n | output | 2 | Card chip selects, active low |
| nmi_arm | output | 1 | Interrupt arm bit |
| nmi_req | output | 1 | Interrupt request |
| dout | output | 8 | Data bus to processor |
| dout_oe | output | 1 | Data bus output enable |

## Verification
Written state (the card selects and the arm bit) is due on the second rising edge after a write strobe opens. The bench compares it at the falling edge that follows that edge. Read data, output enable and the interrupt request are combinational, so they are compared one falling edge after the inputs are applied, while the inputs are still held. Each expected item carries the cycle in which it is due, and the monitor checks it only in that cycle. A second instance built in reduced mode shares the bus, so the R8 checks run in the same cycles as the rest.

// File: rtl/cs_joy_port.sv
module cs_joy_port #(
  parameter logic [7:0] PORT_ADDR = 8'h1F,
  parameter int         LATCH_CYC = 1,
  parameter bit         FULL_MODE = 1'b1,
  parameter int         JOY_W     = 5,
  parameter int         DW        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       io_addr,
  input  logic             iorq_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [DW-1:0]    din,
  input  logic [JOY_W-1:0] joy_in,
  input  logic             joy_en_n,
  input  logic             rx_event,
  output logic [1:0]       card_sel_n,
  output logic             nmi_arm,
  output logic             nmi_req,
  output logic [DW-1:0]    dout,
  output logic             dout_oe
);
  localparam int CW = (LATCH_CYC < 2) ? 1 : $clog2(LATCH_CYC + 1);
  localparam logic [CW-1:0] LATCH_AT = CW'(LATCH_CYC);

  logic          hit, wr_hit, rd_hit, captured, take;
  logic [CW-1:0] wcnt;

  assign hit    = ~iorq_n && (io_addr == PORT_ADDR);
  assign wr_hit = hit && ~wr_n;
  assign rd_hit = hit && ~rd_n;
  assign take   = wr_hit && !captured && (wcnt == LATCH_AT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wcnt     <= '0;
      captured <= 1'b0;
    end else if (!wr_hit) begin
      wcnt     <= '0;
      captured <= 1'b0;
    end else if (take) begin
      captured <= 1'b1;
    end else if (!captured) begin
      wcnt <= wcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      card_sel_n <= 2'b11;
      nmi_arm    <= 1'b0;
    end else if (take) begin
      card_sel_n <= (din[1:0] == 2'b00) ? 2'b11 : din[1:0];
      nmi_arm    <= din[3];
    end

  assign nmi_req = nmi_arm && rx_event;

  generate
    if (FULL_MODE) begin : g_full
      assign dout_oe = rd_hit && !joy_en_n;
    end else begin : g_lite
      assign dout_oe = 1'b0;
    end
  endgenerate

  assign dout = dout_oe ? {{(DW-JOY_W){1'b0}}, joy_in} : '0;
endmodule

module cs_joy_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] io_addr,
  input logic       iorq_n,
  input logic       wr_n,
  input logic       joy_en_n,
  input logic       rx_event,
  input logic [1:0] card_sel_n,
  input logic       nmi_arm,
  input logic       nmi_req,
  input logic       dout_oe
);
  logic wr_seen;
  assign wr_seen = ~iorq_n && ~wr_n && (io_addr == 8'h1F);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (card_sel_n == 2'b11 && !nmi_arm));
  assert_never_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    card_sel_n != 2'b00);
  assert_nmi_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> (nmi_arm && rx_event));
  assert_jumper_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    joy_en_n |-> !dout_oe);
  assert_only_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(card_sel_n) |-> $past(wr_seen));
endmodule

bind cs_joy_port cs_joy_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .iorq_n(iorq_n), .wr_n(wr_n),
  .joy_en_n(joy_en_n), .rx_event(rx_event), .card_sel_n(card_sel_n),
  .nmi_arm(nmi_arm), .nmi_req(nmi_req), .dout_oe(dout_oe)
);

// File: tb/tb_cs_joy_port.sv
module tb_cs_joy_port;
  logic clk = 0, rst_n = 0;
  logic [7:0] io_addr = 8'h00, din = 8'h00;
  logic iorq_n = 1, rd_n = 1, wr_n = 1, joy_en_n = 1, rx_event = 0;
  logic [4:0] joy_in = 5'h00;
  logic [1:0] sel, sel_l;
  logic nmi_arm, nmi_req, oe, nmi_arm_l, nmi_req_l, oe_l;
  logic [7:0] dout, dout_l;

  always #4 clk = ~clk;

  cs_joy_port dut (.clk(clk), .rst_n(rst_n), .io_addr(io_addr), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .din(din), .joy_in(joy_in), .joy_en_n(joy_en_n),
    .rx_event(rx_event), .card_sel_n(sel), .nmi_arm(nmi_arm), .nmi_req(nmi_req),
    .dout(dout), .dout_oe(oe));

  cs_joy_port #(.FULL_MODE(1'b0)) dut_lite (.clk(clk), .rst_n(rst_n), .io_addr(io_addr),
    .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .din(din), .joy_in(joy_in),
    .joy_en_n(joy_en_n), .rx_event(rx_event), .card_sel_n(sel_l), .nmi_arm(nmi_arm_l),
    .nmi_req(nmi_req_l), .dout(dout_l), .dout_oe(oe_l));

  typedef struct { int due; logic [16:0] exp; string req; } item_t;
  item_t sbq[$];
  int cyc = 0, total = 0, bad = 0;
  logic [1:0] m_sel = 2'b11;
  logic m_arm = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [16:0] observe();
    return {sel, nmi_arm, nmi_req, oe, dout, oe_l, sel_l, nmi_arm_l};
  endfunction

  function automatic logic [16:0] model(input bit rd_on);
    logic oe_m;
    oe_m = rd_on && !joy_en_n;
    return {m_sel, m_arm, m_arm && rx_event, oe_m, oe_m ? {3'b000, joy_in} : 8'h00,
            1'b0, m_sel, m_arm};
  endfunction

  task automatic push(input int due, input logic [16:0] e, input string r);
    item_t it;
    it.due = due; it.exp = e; it.req = r;
    sbq.push_back(it);
  endtask

  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due == cyc) begin
      item_t it;
      logic [16:0] got;
      it = sbq.pop_front();
      got = observe();
      total++;
      if (got !== it.exp) begin
        bad++;
        $display("FAIL %s cyc=%0d actual=%h expected=%h", it.req, cyc, got, it.exp);
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input int hold,
                           input string r);
    int c0;
    @(negedge clk);
    c0 = cyc; io_addr = a; din = d; iorq_n = 0; wr_n = 0;
    if (a == 8'h1F && hold >= 2) begin
      m_sel = (d[1:0] == 2'b00) ? 2'b11 : d[1:0];
      m_arm = d[3];
    end
    for (int i = 0; i < hold; i++) @(negedge clk);
    iorq_n = 1; wr_n = 1;
    push(c0 + 2 > cyc ? c0 + 2 : cyc, model(1'b0), r);
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [7:0] a, input string r);
    @(negedge clk);
    io_addr = a; iorq_n = 0; rd_n = 0;
    push(cyc + 1, model(a == 8'h1F), r);
    @(negedge clk);
    @(negedge clk);
    iorq_n = 1; rd_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    push(cyc + 1, model(1'b0), "R1");
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    bus_write(8'h1F, 8'h02, 3, "R2 sel0");
    bus_write(8'h1F, 8'h01, 3, "R2 sel1");
    bus_write(8'h1F, 8'h00, 3, "R3 both");
    bus_write(8'h1F, 8'hFC, 3, "R3 R4 both with high bits");
    bus_write(8'h1F, 8'h0A, 3, "R5 arm");
    rx_event = 1;
    bus_read(8'h00, "R5 nmi_req");
    rx_event = 0;
    bus_read(8'h00, "R5 no event");
    bus_write(8'h3F, 8'h01, 3, "R9 other addr");
    bus_write(8'h1F, 8'h01, 1, "R9 short strobe");
    joy_en_n = 0; joy_in = 5'b10101;
    bus_read(8'h1F, "R6 R8 read pattern A");
    joy_in = 5'b01011;
    bus_read(8'h1F, "R6 R8 read pattern B");
    bus_read(8'h3F, "R6 other addr");
    joy_en_n = 1;
    bus_read(8'h1F, "R7 jumper off");
    begin : mid_change
      int c0;
      @(negedge clk);
      c0 = cyc; io_addr = 8'h1F; din = 8'h01; iorq_n = 0; wr_n = 0;
      m_sel = 2'b01; m_arm = 0;
      @(negedge clk); @(negedge clk);
      din = 8'h0A;
      @(negedge clk); @(negedge clk);
      push(cyc, model(1'b0), "R10 single capture");
      @(negedge clk);
      iorq_n = 1; wr_n = 1;
    end
    bus_write(8'h1F, 8'h03, 3, "R2 R8 lite write");
    repeat (4) @(negedge clk);
    if (sbq.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard items left=%0d expected=0", sbq.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule